// File: doc/BRIEF.md
# Infrared Response-Unit Packet Encoder

This block turns one button press on a handheld response unit into the chip stream that switches its infrared emitter. When a press strobe arrives and the block is free, it captures the button number and the 16-bit unit identifier. It then forms a message from a button code, the identifier and an 8-bit checksum. Every message bit leaves the block as a three-chip symbol, and the block steps one chip further on each pulse of a chip-rate tick input. The nominal tick rate is one pulse every 0.5 ms.

The message goes out twice. The first burst is sent as built. After a silent gap, a second burst follows in which every chip is inverted, including the symbol delimiters and the closing pair. A busy flag covers the whole exchange, and the block ignores any press that arrives while it is busy. Carrier modulation, switch debouncing and the indicator lamp are handled elsewhere.

Top module: `irpk_encoder`

## Requirements
- R1: After reset and whenever no exchange is running, `chip_out` is 0 and `busy` is 0.
- R2: In the first burst, each message bit is sent as three consecutive chips: 0, then 1, then the value of the bit.
- R3: The message bits are sent in this order: a 1, the 3-bit button number MSB first, then the unit identifier MSB first.
- R4: The 8-bit checksum follows the identifier, MSB first. It is the sum, modulo 256, of the 4-bit button code (a 1 followed by the button number) and the two bytes of the identifier. The carry out of bit 7 is discarded.
- R5: Each burst closes with a two-chip end pair, 0 then 1, after the last checksum symbol.
- R6: Between the two bursts, the line stays at 0 for exactly `GAP_CHIPS` ticks (default 18).
- R7: The second burst is the first burst with every chip inverted, chip for chip.
- R8: `busy` rises in the cycle after an accepted strobe, with `chip_out` still 0. It falls on the tick after the last chip of the second burst, and `chip_out` returns to 0 on that same tick.
- R9: A strobe that arrives while `busy` is high is ignored. The exchange in progress continues unchanged, and its fields and timing are not affected.
- R10: `chip_out` is registered and changes only in the clock cycle that follows a cycle with `chip_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_tick | input | 1 | One-cycle pulse at the chip rate |
| btn_strobe | input | 1 | Button press request |
| btn_num | input | 3 | Button number, 1 to 5 |
| unit_id | input | 16 | Unit identifier |
| chip_out | output | 1 | Chip-level emitter enable |
| busy | output | 1 | High while an exchange is in progress |

## Verification
Any error in the symbol phase, the bit index or the burst counter shows up at `chip_out` on the very next chip tick. The chip sent would then break the 0,1,data pattern, follow the wrong field order, or make the gap one chip too long or too short. A wrong inversion flag fails the second burst from its first chip onward. A checksum or capture fault appears only in the affected bits, so the test presses use identifiers that set both bytes and force a carry out of the checksum. A busy flag out of step with the sequencer is caught on the cycle after the strobe or at the final tick. It is also caught by a strobe injected while busy, because the chips sent after that strobe must still match the original message.

// File: rtl/irpk_pkg.sv
package irpk_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_DATA,
    SEQ_TAIL,
    SEQ_GAP,
    SEQ_STOP
  } seq_state_e;

  localparam logic [1:0] PH_LEAD  = 2'd0;
  localparam logic [1:0] PH_RISE  = 2'd1;
  localparam logic [1:0] PH_VALUE = 2'd2;

endpackage

// File: rtl/irpk_frame_build.sv
module irpk_frame_build #(
  parameter int NUM_W  = 3,
  parameter int ID_W   = 16,
  parameter int CSUM_W = 8,
  localparam int CODE_W = NUM_W + 1,
  localparam int DBITS  = CODE_W + ID_W + CSUM_W,
  localparam int IDX_W  = $clog2(DBITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [NUM_W-1:0]  btn_num,
  input  logic [ID_W-1:0]   unit_id,
  input  logic [IDX_W-1:0]  bit_idx,
  output logic              data_bit,
  output logic [DBITS-1:0]  frame_q
);

  localparam int NCHUNK = ID_W / CSUM_W;

  logic [CSUM_W-1:0] part [0:NCHUNK];
  logic [DBITS-1:0]  msg;
  logic [DBITS-1:0]  msg_rev;

  // checksum: button code plus each identifier byte, carry dropped
  assign part[0] = {{(CSUM_W-CODE_W){1'b0}}, 1'b1, btn_num};

  for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
    assign part[g+1] = part[g] + unit_id[g*CSUM_W +: CSUM_W];
  end

  assign msg = {1'b1, btn_num, unit_id, part[NCHUNK]};

  // stored reversed so the bit index counts in send order
  for (genvar k = 0; k < DBITS; k++) begin : g_rev
    assign msg_rev[k] = msg[DBITS-1-k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
    end else if (load) begin
      frame_q <= msg_rev;
    end
  end

  assign data_bit = frame_q[bit_idx];

endmodule

// File: rtl/irpk_chip_shape.sv
module irpk_chip_shape
  import irpk_pkg::*;
(
  input  logic       active,
  input  logic       invert,
  input  logic [1:0] phase,
  input  logic       data_bit,
  output logic       chip
);

  logic raw;

  always_comb begin
    unique case (phase)
      PH_LEAD:  raw = 1'b0;
      PH_RISE:  raw = 1'b1;
      default:  raw = data_bit;
    endcase
    chip = active ? (raw ^ invert) : 1'b0;
  end

endmodule

// File: rtl/irpk_sequencer.sv
module irpk_sequencer
  import irpk_pkg::*;
#(
  parameter int DBITS     = 28,
  parameter int GAP_CHIPS = 18,
  localparam int IDX_W    = $clog2(DBITS),
  localparam int GAP_W    = (GAP_CHIPS > 1) ? $clog2(GAP_CHIPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chip_tick,
  input  logic             btn_strobe,
  output logic             load,
  output logic             emit,
  output logic             active,
  output logic             invert,
  output logic [1:0]       phase,
  output logic [IDX_W-1:0] bit_idx,
  output logic             busy_q
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DBITS - 1);
  localparam logic [GAP_W-1:0] LAST_GAP = GAP_W'(GAP_CHIPS - 1);

  seq_state_e       state;
  logic             second;
  logic [GAP_W-1:0] gap_cnt;

  assign load   = (state == SEQ_IDLE) && btn_strobe;
  assign emit   = chip_tick && (state != SEQ_IDLE);
  assign active = (state == SEQ_DATA) || (state == SEQ_TAIL);
  assign invert = second;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      second  <= 1'b0;
      gap_cnt <= '0;
      phase   <= PH_LEAD;
      bit_idx <= '0;
      busy_q  <= 1'b0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (btn_strobe) begin
            state   <= SEQ_DATA;
            second  <= 1'b0;
            phase   <= PH_LEAD;
            bit_idx <= '0;
            busy_q  <= 1'b1;
          end
        end
        SEQ_DATA: begin
          if (chip_tick) begin
            if (phase == PH_VALUE) begin
              phase <= PH_LEAD;
              if (bit_idx == LAST_IDX) begin
                bit_idx <= '0;
                state   <= SEQ_TAIL;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end else begin
              phase <= phase + 2'd1;
            end
          end
        end
        SEQ_TAIL: begin
          if (chip_tick) begin
            if (phase == PH_RISE) begin
              phase   <= PH_LEAD;
              gap_cnt <= '0;
              state   <= second ? SEQ_STOP : SEQ_GAP;
            end else begin
              phase <= PH_RISE;
            end
          end
        end
        SEQ_GAP: begin
          if (chip_tick) begin
            if (gap_cnt == LAST_GAP) begin
              state  <= SEQ_DATA;
              second <= 1'b1;
            end else begin
              gap_cnt <= gap_cnt + 1'b1;
            end
          end
        end
        SEQ_STOP: begin
          if (chip_tick) begin
            state  <= SEQ_IDLE;
            second <= 1'b0;
            busy_q <= 1'b0;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase != 2'd3); // R2

endmodule

// File: rtl/irpk_encoder.sv
module irpk_encoder #(
  parameter int NUM_W     = 3,
  parameter int ID_W      = 16,
  parameter int CSUM_W    = 8,
  parameter int GAP_CHIPS = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chip_tick,
  input  logic             btn_strobe,
  input  logic [NUM_W-1:0] btn_num,
  input  logic [ID_W-1:0]  unit_id,
  output logic             chip_out,
  output logic             busy
);

  localparam int DBITS = NUM_W + 1 + ID_W + CSUM_W;
  localparam int IDX_W = $clog2(DBITS);

  logic             load;
  logic             emit;
  logic             active;
  logic             invert;
  logic [1:0]       phase;
  logic [IDX_W-1:0] bit_idx;
  logic             data_bit;
  logic             next_chip;
  logic [DBITS-1:0] frame_q;

  irpk_sequencer #(
    .DBITS     (DBITS),
    .GAP_CHIPS (GAP_CHIPS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .chip_tick  (chip_tick),
    .btn_strobe (btn_strobe),
    .load       (load),
    .emit       (emit),
    .active     (active),
    .invert     (invert),
    .phase      (phase),
    .bit_idx    (bit_idx),
    .busy_q     (busy)
  );

  irpk_frame_build #(
    .NUM_W  (NUM_W),
    .ID_W   (ID_W),
    .CSUM_W (CSUM_W)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .btn_num  (btn_num),
    .unit_id  (unit_id),
    .bit_idx  (bit_idx),
    .data_bit (data_bit),
    .frame_q  (frame_q)
  );

  irpk_chip_shape u_shape (
    .active   (active),
    .invert   (invert),
    .phase    (phase),
    .data_bit (data_bit),
    .chip     (next_chip)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_out <= 1'b0;
    end else if (emit) begin
      chip_out <= next_chip;
    end
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!chip_out && !busy)); // R1

  AST_BUSY_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(busy)) |-> ($past(btn_strobe) && !chip_out)); // R8

  AST_BUSY_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(busy)) |-> ($past(chip_tick) && !chip_out)); // R8

  AST_FRAME_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(busy)) |-> $stable(frame_q)); // R9

  AST_CHIP_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(chip_tick)) |-> $stable(chip_out)); // R10

endmodule

// File: tb/sim_irpk_encoder.sv
module sim_irpk_encoder;

  localparam int TDIV = 4;
  localparam int GAP  = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        chip_tick = 1'b0;
  logic        btn_strobe = 1'b0;
  logic [2:0]  btn_num = '0;
  logic [15:0] unit_id = '0;
  logic        chip_out;
  logic        busy;

  irpk_encoder u0 (
    .clk        (clk),
    .rst        (rst),
    .chip_tick  (chip_tick),
    .btn_strobe (btn_strobe),
    .btn_num    (btn_num),
    .unit_id    (unit_id),
    .chip_out   (chip_out),
    .busy       (busy)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  bit    q_chip[$];
  bit    q_busy[$];
  string q_tag[$];
  int    tick_cnt = 0;
  bit    tick_prev = 0;
  bit    last_chip = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // monitor: compares the port values after each tick with the scoreboard
  task automatic monitor();
    bit ec, eb;
    string t;
    if (q_chip.size() > 0) begin
      ec = q_chip.pop_front();
      eb = q_busy.pop_front();
      t  = q_tag.pop_front();
      check(chip_out === ec, t, "chip_out", int'(chip_out), int'(ec));
      check(busy === eb, t, "busy", int'(busy), int'(eb));
    end else begin
      check(chip_out === 1'b0 && busy === 1'b0, "R1", "idle chip_out/busy",
            int'({chip_out, busy}), 0);
    end
    last_chip = chip_out;
  endtask

  task automatic step(input bit stb, input logic [2:0] n, input logic [15:0] id);
    @(negedge clk);
    if (tick_prev) monitor();
    else if (!rst) check(chip_out === last_chip, "R10", "chip_out held between ticks",
                         int'(chip_out), int'(last_chip));
    chip_tick  = (tick_cnt == 0);
    tick_prev  = chip_tick;
    tick_cnt   = (tick_cnt + 1) % TDIV;
    btn_strobe = stb;
    btn_num    = n;
    unit_id    = id;
  endtask

  function automatic logic [7:0] csum(input logic [2:0] n, input logic [15:0] id);
    logic [8:0] s;
    s = 9'({1'b1, n}) + 9'(id[15:8]) + 9'(id[7:0]);
    return s[7:0];
  endfunction

  task automatic push_burst(input bit inv, input bit msg[28], input string tb[28]);
    for (int k = 0; k < 28; k++) begin
      q_chip.push_back(1'b0 ^ inv); q_busy.push_back(1'b1); q_tag.push_back(inv ? "R7" : "R2");
      q_chip.push_back(1'b1 ^ inv); q_busy.push_back(1'b1); q_tag.push_back(inv ? "R7" : "R2");
      q_chip.push_back(msg[k] ^ inv); q_busy.push_back(1'b1); q_tag.push_back(inv ? "R7" : tb[k]);
    end
    q_chip.push_back(1'b0 ^ inv); q_busy.push_back(1'b1); q_tag.push_back(inv ? "R7" : "R5");
    q_chip.push_back(1'b1 ^ inv); q_busy.push_back(1'b1); q_tag.push_back(inv ? "R7" : "R5");
  endtask

  // driver: builds the expected chip stream for one press
  task automatic push_frame(input logic [2:0] n, input logic [15:0] id);
    bit msg[28];
    string tb[28];
    logic [7:0] cs;
    cs = csum(n, id);
    msg[0] = 1'b1; tb[0] = "R3";
    for (int k = 0; k < 3; k++)  begin msg[1+k]  = n[2-k];   tb[1+k]  = "R3"; end
    for (int k = 0; k < 16; k++) begin msg[4+k]  = id[15-k]; tb[4+k]  = "R3"; end
    for (int k = 0; k < 8; k++)  begin msg[20+k] = cs[7-k];  tb[20+k] = "R4"; end
    push_burst(1'b0, msg, tb);
    for (int k = 0; k < GAP; k++) begin
      q_chip.push_back(1'b0); q_busy.push_back(1'b1); q_tag.push_back("R6");
    end
    push_burst(1'b1, msg, tb);
    q_chip.push_back(1'b0); q_busy.push_back(1'b0); q_tag.push_back("R8");
  endtask

  task automatic press(input logic [2:0] n, input logic [15:0] id, input int inject_at);
    int k;
    while (tick_cnt == 0) step(0, n, id);
    step(1, n, id);
    push_frame(n, id);
    step(0, n, id);
    check(busy === 1'b1 && chip_out === 1'b0, "R8", "busy after strobe",
          int'({busy, chip_out}), 2);
    k = 0;
    while (q_chip.size() > 0) begin
      if (k == inject_at && busy) begin
        step(1, 3'd2, 16'h1234);
        step(0, n, id);
        check(busy === 1'b1, "R9", "busy after ignored strobe", int'(busy), 1);
      end else begin
        step(0, n, id);
      end
      k++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) step(0, 3'd0, 16'h0);
    rst = 1'b0;
    step(0, 3'd0, 16'h0);
    check(chip_out === 1'b0 && busy === 1'b0, "R1", "reset state",
          int'({chip_out, busy}), 0);
    press(3'd1, 16'd55573, -1);           // checksum 247
    repeat (12) step(0, 3'd0, 16'h0);
    press(3'd5, 16'hFFFF, 100);           // checksum carry dropped, strobe ignored
    repeat (12) step(0, 3'd0, 16'h0);
    press(3'd3, 16'h0000, 450);           // strobe ignored during gap/second burst
    press(3'd4, 16'hA5C3, 30);            // back-to-back press
    repeat (12) step(0, 3'd0, 16'h0);
    finished = 1;
    report();
    $finish;
  end

endmodule